// File: doc/BRIEF.md
# Network Controller Command and Run-State Register

This block holds the host-visible command byte of a packet network controller and owns the controller's run state. A host writes and reads one 8-bit register through a plain strobe port. The byte carries a stop flag, a start flag, a transmit request, a three-bit remote DMA command and a two-bit register page select. The DMA command and page select are decoded for neighbouring logic. The transmit request is handed to an external transmit engine, which clears it by reporting completion or abort.

Run state has three phases: running, draining and halted. When stop is raised while running, the controller drops offline at once, so no new frame may begin. It then waits until the receive and transmit datapaths both report idle. Only then does it enter the halted state and raise a reset-complete flag. The host clears that flag by pulsing a clear input. To return online, the host must write stop low and start high. No data stream passes through this block, so every pin is a plain control or status signal and no valid/ready handshake applies.

Top module: `ncr_cmd_top`

## Requirements
- R1: A write stores bit 0 as stop, bit 1 as start, bit 2 as transmit request, bits 5:3 as the DMA command and bits 7:6 as page select. `reg_rdata` returns these fields in the same positions, combinationally from the stored state.
- R2: After reset, `reg_rdata` is 0x01 (stop set, all else clear), `online` and `tx_go` are low, and `rst_flag` is high.
- R3: If a write sets bit 0 while the stored start bit is 1, start stays 1 whatever bit 1 of the write holds. Otherwise start takes bit 1 of the write.
- R4: Writing 1 to bit 2 sets the transmit request. Writing 0 to bit 2 leaves it unchanged.
- R5: A pulse on `tx_done` or `tx_abort` clears the transmit request at the next edge. If a write setting bit 2 lands in the same cycle, the set wins.
- R6: `online` is high only while running with start set, and it falls the cycle after stop is stored. `tx_go` equals transmit request AND `online`.
- R7: After a stop, the halted state and `rst_flag` are reached only at an edge where both `rx_busy` and `tx_busy` are low. While either is high, `rst_flag` stays low.
- R8: A pulse on `rstf_clr` clears `rst_flag`. Entry into the halted state sets it, and setting has priority over clearing.
- R9: From the halted state, the controller runs again only once stop is 0 and start is 1. `online` rises one cycle after that value is stored.
- R10: `dma_cmd` mirrors bits 5:3. `page_hit` is one-hot for page values 0, 1 and 2, with bit n standing for page n. `page_hit` is all zero for the reserved value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current command byte |
| rstf_clr | input | 1 | Pulse to clear the reset-complete flag |
| tx_done | input | 1 | Transmit engine finished a frame |
| tx_abort | input | 1 | Transmit engine abandoned a frame |
| rx_busy | input | 1 | A reception is in progress |
| tx_busy | input | 1 | A transmission is in progress |
| online | output | 1 | Controller is running and may start traffic |
| tx_go | output | 1 | Transmit request qualified by online |
| rst_flag | output | 1 | Reset-complete status flag |
| dma_cmd | output | 3 | Stored remote DMA command |
| page_hit | output | 3 | One-hot register page decode |

## Verification
The hardest situation to produce from the ports is a stop that arrives while traffic is still in flight, with the two busy lines dropping on different cycles. The stimulus raises both busy lines before it writes stop. It holds them across several cycles while it checks that the flag stays low. It then releases receive first and transmit later, in the same cycle as a transmit-done pulse. This shows that halting waits for the last line to go idle and that the transmit request clears on that edge. A second hard case is a write that sets the transmit bit in the same cycle as a done pulse. The bench times it on a single edge to show that the set wins.

// File: rtl/ncr_pkg.sv
package ncr_pkg;
  localparam int DMA_W   = 3;
  localparam int PAGE_W  = 2;
  localparam int REG_W   = 3 + DMA_W + PAGE_W;
  localparam int STOP_B  = 0;
  localparam int START_B = 1;
  localparam int TXRQ_B  = 2;
  localparam int DMA_LSB = 3;
  localparam int PG_LSB  = DMA_LSB + DMA_W;

  typedef enum logic [1:0] {
    RS_RUN   = 2'd0,
    RS_DRAIN = 2'd1,
    RS_HALT  = 2'd2
  } run_state_e;
endpackage

// File: rtl/ncr_cmd_bits.sv
module ncr_cmd_bits
  import ncr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              tx_fin,
  output logic              stop_q,
  output logic              start_q,
  output logic              txrq_q,
  output logic [DMA_W-1:0]  dma_q,
  output logic [PAGE_W-1:0] page_q
);
  logic start_next;

  // start survives a stop write when it was already set
  always_comb begin
    start_next = wdata[START_B] | (wdata[STOP_B] & start_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= 1'b1;
      start_q <= 1'b0;
      dma_q   <= '0;
      page_q  <= '0;
    end else if (wr) begin
      stop_q  <= wdata[STOP_B];
      start_q <= start_next;
      dma_q   <= wdata[DMA_LSB +: DMA_W];
      page_q  <= wdata[PG_LSB +: PAGE_W];
    end
  end

  // set-only from the host, cleared by the transmit engine; set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      txrq_q <= 1'b0;
    else if (wr && wdata[TXRQ_B])    txrq_q <= 1'b1;
    else if (tx_fin)                 txrq_q <= 1'b0;
  end
endmodule

// File: rtl/ncr_run_seq.sv
module ncr_run_seq
  import ncr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_q,
  input  logic start_q,
  input  logic rx_busy,
  input  logic tx_busy,
  input  logic flag_clr,
  output logic online,
  output logic rst_flag
);
  run_state_e state_q, state_d;
  logic       idle;
  logic       enter_halt;

  assign idle       = !rx_busy && !tx_busy;
  assign enter_halt = (state_q == RS_DRAIN) && idle;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_RUN:   if (stop_q)              state_d = RS_DRAIN;
      RS_DRAIN: if (idle)                state_d = RS_HALT;
      RS_HALT:  if (!stop_q && start_q)  state_d = RS_RUN;
      default:                           state_d = RS_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RS_HALT;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rst_flag <= 1'b1;
    else if (enter_halt) rst_flag <= 1'b1;
    else if (flag_clr)   rst_flag <= 1'b0;
  end

  assign online = (state_q == RS_RUN) && start_q && !stop_q;
endmodule

// File: rtl/ncr_page_dec.sv
module ncr_page_dec
  import ncr_pkg::*;
#(
  parameter int NUM_PAGES = 3
) (
  input  logic [PAGE_W-1:0]    page,
  output logic [NUM_PAGES-1:0] hit
);
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    assign hit[g] = (page == PAGE_W'(g));
  end
endmodule

// File: rtl/ncr_cmd_top.sv
module ncr_cmd_top
  import ncr_pkg::*;
#(
  parameter int NUM_PAGES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 rstf_clr,
  input  logic                 tx_done,
  input  logic                 tx_abort,
  input  logic                 rx_busy,
  input  logic                 tx_busy,
  output logic                 online,
  output logic                 tx_go,
  output logic                 rst_flag,
  output logic [DMA_W-1:0]     dma_cmd,
  output logic [NUM_PAGES-1:0] page_hit
);
  logic              stop_q, start_q, txrq_q;
  logic [DMA_W-1:0]  dma_q;
  logic [PAGE_W-1:0] page_q;

  ncr_cmd_bits u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .tx_fin  (tx_done | tx_abort),
    .stop_q  (stop_q),
    .start_q (start_q),
    .txrq_q  (txrq_q),
    .dma_q   (dma_q),
    .page_q  (page_q)
  );

  ncr_run_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_q   (stop_q),
    .start_q  (start_q),
    .rx_busy  (rx_busy),
    .tx_busy  (tx_busy),
    .flag_clr (rstf_clr),
    .online   (online),
    .rst_flag (rst_flag)
  );

  ncr_page_dec #(.NUM_PAGES(NUM_PAGES)) u_pdec (
    .page (page_q),
    .hit  (page_hit)
  );

  assign reg_rdata = {page_q, dma_q, txrq_q, start_q, stop_q};
  assign dma_cmd   = dma_q;
  assign tx_go     = txrq_q && online;
endmodule

// File: rtl/ncr_cmd_checker.sv
module ncr_cmd_checker
  import ncr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             tx_done,
  input logic             tx_abort,
  input logic             rx_busy,
  input logic             tx_busy,
  input logic             online,
  input logic             tx_go,
  input logic             rst_flag
);
  // R5: a finish pulse with no concurrent set clears the request
  a_r5_tx_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done || tx_abort) && !(reg_wr && reg_wdata[TXRQ_B]) |=> !reg_rdata[TXRQ_B]);

  // R4: without a finish pulse the request holds
  a_r4_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[TXRQ_B] && !tx_done && !tx_abort |=> reg_rdata[TXRQ_B]);

  // R3: a stop write keeps an already set start
  a_r3_stop_keeps_start: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[STOP_B] && reg_rdata[START_B] |=> reg_rdata[START_B] && reg_rdata[STOP_B]);

  // R7: the flag rises only after an idle sample
  a_r7_flag_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_flag) |-> $past(!rx_busy && !tx_busy));

  // R6: online needs start set
  a_r6_online_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    online |-> reg_rdata[START_B]);

  // R6: transmit go needs both online and a request
  a_r6_go_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> online && reg_rdata[TXRQ_B]);

  // R9: coming online follows stop low and start high
  a_r9_resume_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(online) |-> $past(!reg_rdata[STOP_B] && reg_rdata[START_B]));
endmodule

bind ncr_cmd_top ncr_cmd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .tx_done   (tx_done),
  .tx_abort  (tx_abort),
  .rx_busy   (rx_busy),
  .tx_busy   (tx_busy),
  .online    (online),
  .tx_go     (tx_go),
  .rst_flag  (rst_flag)
);

// File: tb/ncr_cmd_top_bench.sv
module ncr_cmd_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rstf_clr = 1'b0;
  logic       tx_done = 1'b0;
  logic       tx_abort = 1'b0;
  logic       rx_busy = 1'b0;
  logic       tx_busy = 1'b0;
  logic       online, tx_go, rst_flag;
  logic [2:0] dma_cmd;
  logic [2:0] page_hit;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  ncr_cmd_top u_ncr_cmd_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rstf_clr(rstf_clr), .tx_done(tx_done),
    .tx_abort(tx_abort), .rx_busy(rx_busy), .tx_busy(tx_busy),
    .online(online), .tx_go(tx_go), .rst_flag(rst_flag),
    .dma_cmd(dma_cmd), .page_hit(page_hit)
  );

  // {write value, expected read-back}; run from halted with idle datapath
  localparam logic [15:0] VEC [8] = '{
    {8'h00, 8'h00},  // R1 all clear
    {8'hC9, 8'hC9},  // R1 page 3, dma 1, stop
    {8'h52, 8'h52},  // R1 start, begins running
    {8'h81, 8'h83},  // R3 stop while started keeps start
    {8'h20, 8'h20},  // R1 dma 4 only
    {8'h03, 8'h03},  // R1 stop and start
    {8'h01, 8'h03},  // R3 start retained
    {8'h00, 8'h00}   // R1 clear
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); rstf_clr = 1'b1;
    @(negedge clk); rstf_clr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R2 reset state
    chk("R2 rdata", reg_rdata, 8'h01);
    chk("R2 online", online, 1'b0);
    chk("R2 tx_go", tx_go, 1'b0);
    chk("R2 rst_flag", rst_flag, 1'b1);

    pulse_clr();
    chk("R8 flag cleared", rst_flag, 1'b0);

    for (int i = 0; i < 8; i++) begin
      wr_reg(VEC[i][15:8]);
      chk("R1/R3 table", reg_rdata, VEC[i][7:0]);
    end
    chk("R7 flag after idle stop", rst_flag, 1'b1);

    // R10 decodes
    wr_reg(8'h80);
    chk("R10 page 2", page_hit, 3'b100);
    wr_reg(8'h68);
    chk("R10 page 1", page_hit, 3'b010);
    chk("R10 dma", dma_cmd, 3'd5);
    wr_reg(8'hC0);
    chk("R10 page reserved", page_hit, 3'b000);
    wr_reg(8'h00);
    chk("R10 page 0", page_hit, 3'b001);

    pulse_clr();
    chk("R8 flag clear again", rst_flag, 1'b0);

    // R9 no start: stays offline
    wait_cyc(3);
    chk("R9 no start offline", online, 1'b0);
    wr_reg(8'h02);
    chk("R9 not yet online", online, 1'b0);
    wait_cyc(1);
    chk("R9 online", online, 1'b1);

    // R4 / R5 transmit request
    wr_reg(8'h06);
    chk("R4 tx set", reg_rdata[2], 1'b1);
    chk("R6 tx_go", tx_go, 1'b1);
    wr_reg(8'h02);
    chk("R4 write 0 no effect", reg_rdata[2], 1'b1);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    chk("R5 cleared by done", reg_rdata[2], 1'b0);
    wr_reg(8'h06);
    @(negedge clk); tx_abort = 1'b1;
    @(negedge clk); tx_abort = 1'b0;
    chk("R5 cleared by abort", reg_rdata[2], 1'b0);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h06; tx_done = 1'b1;
    @(negedge clk); reg_wr = 1'b0; tx_done = 1'b0;
    chk("R5 set wins", reg_rdata[2], 1'b1);

    // R6 / R7 drain with traffic in flight
    @(negedge clk); rx_busy = 1'b1; tx_busy = 1'b1;
    wr_reg(8'h05);
    chk("R3 stop keeps start", reg_rdata, 8'h07);
    wait_cyc(1);
    chk("R6 offline after stop", online, 1'b0);
    chk("R6 tx_go low", tx_go, 1'b0);
    wait_cyc(4);
    chk("R7 flag held while busy", rst_flag, 1'b0);
    rx_busy = 1'b0;
    wait_cyc(2);
    chk("R7 flag held tx busy", rst_flag, 1'b0);
    tx_busy = 1'b0; tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    chk("R7 flag on idle", rst_flag, 1'b1);
    chk("R5 request cleared", reg_rdata[2], 1'b0);

    // R9 stop and start both set: remain halted
    wait_cyc(3);
    chk("R9 halted while stop", online, 1'b0);
    wr_reg(8'h02);
    wait_cyc(1);
    chk("R9 resume", online, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule